// File: doc/BRIEF.md
# Vertical-Flip Line Burst Reader

This block drains one stored video frame from external memory in reverse line order, so the picture that leaves it is mirrored top to bottom. A separate writer fills two frame buffers in turn. When the writer finishes a frame, it pulses an end-of-frame input and names the buffer it has just completed. The reader then issues one read command per line. It starts at the bottom line of that buffer and steps upward, one line length at a time, until it has read the top line. Each command carries a byte address and a beat count equal to the pixels in a line.

Read data comes back as a stream of 32-bit words. The low half of each word holds the pixel, so the reader keeps that half and forwards it, one cycle later, to a downstream buffer. The first pixel of a frame is marked start-of-frame and the last pixel of every line is marked end-of-line. The downstream buffer has no ready signal. Instead it raises an almost-full flag, and the reader checks that flag only before it issues a new line command. A burst that has begun always runs to the end, so the buffer must keep at least one line of headroom below its almost-full point.

The return stream uses valid/ready. The reader raises ready for the whole of a burst and never drops it part-way through. The memory side may leave gaps in valid at any point. The command channel also uses valid/ready: while the command is waiting for ready, its address and length stay constant. If the writer completes another frame while the reader is still busy, the reader raises a one-cycle frame-drop error. It then finishes the frame it is reading and continues with the newest completed buffer.

Top module: `flip_line_reader`

## Requirements
- R1: While reset is held, cmd_valid_o, rd_ready_o, px_valid_o and frame_drop_o are all low.
- R2: After an end-of-frame pulse that arrives while the reader is idle, the first command addresses the last line of the selected buffer: base + (LINES-1)*LINE_PIX*4. Its length is LINE_PIX beats.
- R3: Each later command of the same frame addresses exactly LINE_PIX*4 bytes below the previous one. A frame is exactly LINES commands, and the last of them addresses the buffer base.
- R4: One command is issued per line. The next command is not presented until all LINE_PIX beats of the current line have been accepted, and cmd_valid_o is never high while rd_ready_o is high.
- R5: A new command is presented only if ds_afull_i was low in the cycle before cmd_valid_o rises. While ds_afull_i stays high between bursts, no command is issued.
- R6: Once a burst has started, rd_ready_o stays high until its last beat is accepted, whatever ds_afull_i does.
- R7: While cmd_valid_o is high and cmd_ready_i is low, cmd_valid_o stays high and cmd_addr_o stays unchanged.
- R8: Every accepted return beat appears on the next cycle as a pixel. px_data_o holds bits 15:0 of the word, px_sof_o marks the first pixel of the frame and px_eol_o marks the last pixel of each line.
- R9: After the last line of a frame, no command is issued until the next end-of-frame pulse.
- R10: An end-of-frame pulse that arrives while a frame is being read or is pending raises frame_drop_o for one cycle on the next cycle. The current frame still completes, and the reader then reads the buffer named by that newest pulse.
- R11: frame_buf_i = 0 selects BASE0 and frame_buf_i = 1 selects BASE1 as the buffer base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_done_i | input | 1 | One-cycle end-of-frame pulse from the writer |
| frame_buf_i | input | 1 | Buffer the writer just completed, sampled with frame_done_i |
| ds_afull_i | input | 1 | Downstream buffer almost full; holds back new line commands |
| cmd_valid_o | output | 1 | Read command valid |
| cmd_ready_i | input | 1 | Memory accepts the command |
| cmd_addr_o | output | ADDR_W | Byte address of the line |
| cmd_len_o | output | LEN_W | Beats in the burst (LINE_PIX) |
| rd_valid_i | input | 1 | Return word valid |
| rd_ready_o | output | 1 | Reader accepts return words (whole burst) |
| rd_data_i | input | 32 | Return word, pixel in bits 15:0 |
| px_valid_o | output | 1 | Pixel valid toward the downstream buffer |
| px_data_o | output | 16 | Pixel value |
| px_sof_o | output | 1 | First pixel of a frame |
| px_eol_o | output | 1 | Last pixel of a line |
| frame_drop_o | output | 1 | One-cycle frame-drop error |

## Verification
The assertions rely on a memory side that returns exactly the command's length in beats, with no extra beats. They also rely on rd_valid_i appearing only after a command has been accepted, and on end-of-frame arriving as a single-cycle pulse. The bench's memory model drives return data only while a burst from an accepted command still has beats outstanding. It pulses frame_done_i for exactly one cycle, and it can insert gaps in valid and stalls in command ready without breaking those assumptions. The almost-full input is toggled freely, including in the middle of a burst, because the design must tolerate it at any time.

// File: rtl/flip_rd_pkg.sv
package flip_rd_pkg;
  typedef enum logic [1:0] {
    RD_IDLE,
    RD_WAIT,
    RD_CMD,
    RD_DATA
  } rd_state_e;
endpackage

// File: rtl/flip_rd_addr.sv
// Line address generator: loads the top-of-buffer offset, then steps down.
module flip_rd_addr #(
  parameter int ADDR_W = 32,
  parameter int LINES = 1080,
  parameter int LINE_PIX = 1920,
  parameter logic [ADDR_W-1:0] BASE0 = '0,
  parameter logic [ADDR_W-1:0] BASE1 = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              buf_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam logic [ADDR_W-1:0] LINE_BYTES = ADDR_W'(LINE_PIX * 4);
  localparam logic [ADDR_W-1:0] TOP_OFS    = ADDR_W'((LINES - 1) * LINE_PIX * 4);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_o <= '0;
    end else if (load_i) begin
      addr_o <= (buf_i ? BASE1 : BASE0) + TOP_OFS;
    end else if (step_i) begin
      addr_o <= addr_o - LINE_BYTES;
    end
  end
endmodule

// File: rtl/flip_rd_seq.sv
// Frame and line sequencer: pending-frame tracking, burst gating, beat counting.
module flip_rd_seq
  import flip_rd_pkg::*;
#(
  parameter int LINES = 1080,
  parameter int LINE_PIX = 1920
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_done_i,
  input  logic frame_buf_i,
  input  logic ds_afull_i,
  input  logic cmd_ready_i,
  input  logic rd_valid_i,
  output logic cmd_valid_o,
  output logic rd_ready_o,
  output logic load_o,
  output logic buf_o,
  output logic step_o,
  output logic sof_o,
  output logic eol_o,
  output logic frame_drop_o
);
  localparam int LW = (LINES > 1) ? $clog2(LINES) : 1;
  localparam int BW = (LINE_PIX > 1) ? $clog2(LINE_PIX) : 1;
  localparam logic [LW-1:0] LAST_LINE = LW'(LINES - 1);
  localparam logic [BW-1:0] LAST_BEAT = BW'(LINE_PIX - 1);

  rd_state_e state_q, state_d;
  logic          pend_q, pend_buf_q;
  logic [LW-1:0] line_q;
  logic [BW-1:0] beat_q;
  logic busy, take, beat_acc, last_beat, last_line;

  assign busy      = (state_q != RD_IDLE) || pend_q;
  assign take      = (state_q == RD_IDLE) && pend_q;
  assign beat_acc  = (state_q == RD_DATA) && rd_valid_i;
  assign last_beat = (beat_q == LAST_BEAT);
  assign last_line = (line_q == LAST_LINE);

  assign cmd_valid_o = (state_q == RD_CMD);
  assign rd_ready_o  = (state_q == RD_DATA);
  assign load_o      = take;
  assign buf_o       = pend_buf_q;
  assign step_o      = beat_acc && last_beat && !last_line;
  assign sof_o       = (line_q == '0) && (beat_q == '0);
  assign eol_o       = last_beat;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      RD_IDLE: if (take) state_d = RD_WAIT;
      RD_WAIT: if (!ds_afull_i) state_d = RD_CMD;
      RD_CMD:  if (cmd_ready_i) state_d = RD_DATA;
      RD_DATA: if (beat_acc && last_beat) state_d = last_line ? RD_IDLE : RD_WAIT;
      default: state_d = RD_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= RD_IDLE;
      pend_q       <= 1'b0;
      pend_buf_q   <= 1'b0;
      line_q       <= '0;
      beat_q       <= '0;
      frame_drop_o <= 1'b0;
    end else begin
      state_q      <= state_d;
      frame_drop_o <= frame_done_i && busy;
      if (frame_done_i) begin
        pend_q     <= 1'b1;
        pend_buf_q <= frame_buf_i;
      end else if (take) begin
        pend_q <= 1'b0;
      end
      if (take) line_q <= '0;
      else if (beat_acc && last_beat && !last_line) line_q <= line_q + 1'b1;
      if (cmd_valid_o && cmd_ready_i) beat_q <= '0;
      else if (beat_acc) beat_q <= last_beat ? '0 : beat_q + 1'b1;
    end
  end

  assert_afull_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_valid_o) |-> !$past(ds_afull_i));
  assert_no_pause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ready_o && !(rd_valid_i && last_beat)) |=> rd_ready_o);
  assert_one_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ready_o |-> !cmd_valid_o);
  assert_drop_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_drop_o |-> $past(frame_done_i));
endmodule

// File: rtl/flip_rd_pix.sv
// Pixel output stage: one register, keeps the low half of each word.
module flip_rd_pix #(
  parameter int PIX_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat_i,
  input  logic [PIX_W-1:0] data_i,
  input  logic             sof_i,
  input  logic             eol_i,
  output logic             px_valid_o,
  output logic [PIX_W-1:0] px_data_o,
  output logic             px_sof_o,
  output logic             px_eol_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      px_valid_o <= 1'b0;
      px_data_o  <= '0;
      px_sof_o   <= 1'b0;
      px_eol_o   <= 1'b0;
    end else begin
      px_valid_o <= beat_i;
      px_sof_o   <= beat_i && sof_i;
      px_eol_o   <= beat_i && eol_i;
      if (beat_i) px_data_o <= data_i;
    end
  end
endmodule

// File: rtl/flip_line_reader.sv
module flip_line_reader #(
  parameter int ADDR_W = 32,
  parameter int LINES = 1080,
  parameter int LINE_PIX = 1920,
  parameter logic [ADDR_W-1:0] BASE0 = 32'h0000_0000,
  parameter logic [ADDR_W-1:0] BASE1 = 32'h0100_0000,
  parameter int LEN_W = $clog2(LINE_PIX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_done_i,
  input  logic              frame_buf_i,
  input  logic              ds_afull_i,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [LEN_W-1:0]  cmd_len_o,
  input  logic              rd_valid_i,
  output logic              rd_ready_o,
  input  logic [31:0]       rd_data_i,
  output logic              px_valid_o,
  output logic [15:0]       px_data_o,
  output logic              px_sof_o,
  output logic              px_eol_o,
  output logic              frame_drop_o
);
  logic load, bsel, step, sof, eol;
  logic unused_hi;

  assign unused_hi = ^rd_data_i[31:16];
  assign cmd_len_o = LEN_W'(LINE_PIX);

  flip_rd_seq #(.LINES(LINES), .LINE_PIX(LINE_PIX)) seq_i (
    .clk(clk), .rst_n(rst_n), .frame_done_i(frame_done_i), .frame_buf_i(frame_buf_i),
    .ds_afull_i(ds_afull_i), .cmd_ready_i(cmd_ready_i), .rd_valid_i(rd_valid_i),
    .cmd_valid_o(cmd_valid_o), .rd_ready_o(rd_ready_o), .load_o(load), .buf_o(bsel),
    .step_o(step), .sof_o(sof), .eol_o(eol), .frame_drop_o(frame_drop_o)
  );

  flip_rd_addr #(.ADDR_W(ADDR_W), .LINES(LINES), .LINE_PIX(LINE_PIX),
                 .BASE0(BASE0), .BASE1(BASE1)) addr_i (
    .clk(clk), .rst_n(rst_n), .load_i(load), .buf_i(bsel), .step_i(step),
    .addr_o(cmd_addr_o)
  );

  flip_rd_pix #(.PIX_W(16)) pix_i (
    .clk(clk), .rst_n(rst_n), .beat_i(rd_valid_i && rd_ready_o),
    .data_i(rd_data_i[15:0]), .sof_i(sof), .eol_i(eol),
    .px_valid_o(px_valid_o), .px_data_o(px_data_o), .px_sof_o(px_sof_o),
    .px_eol_o(px_eol_o)
  );

  assert_cmd_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && !cmd_ready_i) |=> (cmd_valid_o && $stable(cmd_addr_o)));
  assert_pix_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    px_valid_o |-> $past(rd_valid_i && rd_ready_o));
  assert_pix_tags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (px_sof_o || px_eol_o) |-> px_valid_o);
endmodule

// File: tb/flip_line_reader_tb.sv
module flip_line_reader_tb_top;
  localparam int LINES = 3;
  localparam int LINE_PIX = 4;
  localparam int ADDR_W = 32;
  localparam int LEN_W = $clog2(LINE_PIX + 1);
  localparam logic [31:0] B0 = 32'h0000_1000;
  localparam logic [31:0] B1 = 32'h0002_2000;
  localparam int FPIX = LINES * LINE_PIX;

  logic clk = 1'b0, rst_n = 1'b0;
  logic frame_done_i = 1'b0, frame_buf_i = 1'b0, ds_afull_i = 1'b0;
  logic cmd_valid_o, cmd_ready_i, rd_valid_i, rd_ready_o;
  logic [ADDR_W-1:0] cmd_addr_o;
  logic [LEN_W-1:0] cmd_len_o;
  logic [31:0] rd_data_i;
  logic px_valid_o, px_sof_o, px_eol_o, frame_drop_o;
  logic [15:0] px_data_o;

  always #2.5 clk = ~clk;

  flip_line_reader #(.ADDR_W(ADDR_W), .LINES(LINES), .LINE_PIX(LINE_PIX),
                     .BASE0(B0), .BASE1(B1)) dut_i (
    .clk(clk), .rst_n(rst_n), .frame_done_i(frame_done_i), .frame_buf_i(frame_buf_i),
    .ds_afull_i(ds_afull_i), .cmd_valid_o(cmd_valid_o), .cmd_ready_i(cmd_ready_i),
    .cmd_addr_o(cmd_addr_o), .cmd_len_o(cmd_len_o), .rd_valid_i(rd_valid_i),
    .rd_ready_o(rd_ready_o), .rd_data_i(rd_data_i), .px_valid_o(px_valid_o),
    .px_data_o(px_data_o), .px_sof_o(px_sof_o), .px_eol_o(px_eol_o),
    .frame_drop_o(frame_drop_o)
  );

  int n_chk = 0, n_err = 0;
  bit stall_mode = 0, gap_mode = 0;
  int unsigned cmd_a_q[$];
  int cmd_l_q[$], cmd_b_q[$];
  int px_d_q[$];
  bit px_s_q[$], px_e_q[$];
  int beat_total = 0, stall_cnt = 0, drop_cnt = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Memory model: accepts commands, returns len words holding (addr>>2)+beat.
  initial begin
    int unsigned r_addr;
    int r_left, r_beat;
    bit tog;
    r_addr = 0; r_left = 0; r_beat = 0; tog = 0;
    rd_valid_i = 1'b0; rd_data_i = '0; cmd_ready_i = 1'b0;
    forever begin
      @(posedge clk);
      if (!rst_n) begin
        r_left = 0;
        rd_valid_i <= 1'b0;
        cmd_ready_i <= 1'b0;
      end else begin
        if (rd_valid_i && !rd_ready_o) stall_cnt++;
        if (rd_valid_i && rd_ready_o) begin
          r_beat++; r_left--; beat_total++;
        end
        if (cmd_valid_o && cmd_ready_i) begin
          cmd_a_q.push_back(cmd_addr_o);
          cmd_l_q.push_back(int'(cmd_len_o));
          cmd_b_q.push_back(beat_total);
          r_addr = cmd_addr_o; r_left = int'(cmd_len_o); r_beat = 0;
        end
        tog = ~tog;
        rd_valid_i  <= (r_left > 0) && (!gap_mode || tog);
        rd_data_i   <= {16'hC3C3, 16'((r_addr >> 2) + r_beat)};
        cmd_ready_i <= !stall_mode || tog;
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (px_valid_o) begin
          px_d_q.push_back(int'(px_data_o));
          px_s_q.push_back(px_sof_o);
          px_e_q.push_back(px_eol_o);
        end
        if (frame_drop_o) drop_cnt++;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  task automatic clear_logs();
    cmd_a_q.delete(); cmd_l_q.delete(); cmd_b_q.delete();
    px_d_q.delete(); px_s_q.delete(); px_e_q.delete();
    drop_cnt = 0; stall_cnt = 0;
  endtask

  task automatic pulse_done(input bit b);
    @(negedge clk);
    frame_done_i = 1'b1; frame_buf_i = b;
    @(negedge clk);
    frame_done_i = 1'b0;
  endtask

  task automatic wait_px(input int n);
    int t;
    t = 0;
    while (px_d_q.size() < n && t < 2000) begin
      @(negedge clk); t++;
    end
    chk(px_d_q.size() >= n, "R8", "pixel count reached", px_d_q.size(), n);
  endtask

  // Checks one frame of commands (from index ci) and pixels (from index pi).
  task automatic check_frame(input int ci, input int pi, input int unsigned base, input string tag);
    bit ok_a, ok_l, ok_b, ok_d, ok_s, ok_e;
    ok_a = 1; ok_l = 1; ok_b = 1; ok_d = 1; ok_s = 1; ok_e = 1;
    chk(cmd_a_q.size() >= ci + LINES, "R3", {tag, " command count"}, cmd_a_q.size(), ci + LINES);
    chk(px_d_q.size() >= pi + FPIX, "R8", {tag, " pixel count"}, px_d_q.size(), pi + FPIX);
    if (cmd_a_q.size() >= ci + LINES && px_d_q.size() >= pi + FPIX) begin
      chk(cmd_a_q[ci] == base + (LINES - 1) * LINE_PIX * 4, "R2", {tag, " first address"},
          cmd_a_q[ci], base + (LINES - 1) * LINE_PIX * 4);
      for (int i = 0; i < LINES; i++) begin
        if (cmd_a_q[ci + i] != base + (LINES - 1 - i) * LINE_PIX * 4) ok_a = 0;
        if (cmd_l_q[ci + i] != LINE_PIX) ok_l = 0;
        if (cmd_b_q[ci + i] - cmd_b_q[ci] != i * LINE_PIX) ok_b = 0;
        for (int j = 0; j < LINE_PIX; j++) begin
          int k;
          k = pi + i * LINE_PIX + j;
          if (px_d_q[k] != int'(16'((base >> 2) + (LINES - 1 - i) * LINE_PIX + j))) ok_d = 0;
          if (px_s_q[k] != (i == 0 && j == 0)) ok_s = 0;
          if (px_e_q[k] != (j == LINE_PIX - 1)) ok_e = 0;
        end
      end
      chk(ok_a, "R3", {tag, " descending line addresses"}, ok_a, 1);
      chk(cmd_a_q[ci + LINES - 1] == base, "R11", {tag, " last address is base"},
          cmd_a_q[ci + LINES - 1], base);
      chk(ok_l, "R2", {tag, " burst length"}, ok_l, 1);
      chk(ok_b, "R4", {tag, " full line between commands"}, ok_b, 1);
      chk(ok_d, "R8", {tag, " pixel low half"}, ok_d, 1);
      chk(ok_s, "R8", {tag, " start-of-frame tag"}, ok_s, 1);
      chk(ok_e, "R8", {tag, " end-of-line tag"}, ok_e, 1);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(!cmd_valid_o && !rd_ready_o && !px_valid_o && !frame_drop_o, "R1", "outputs in reset",
        {cmd_valid_o, rd_ready_o, px_valid_o, frame_drop_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_basic();
    clear_logs();
    pulse_done(1'b0);
    wait_px(FPIX);
    repeat (4) @(negedge clk);
    check_frame(0, 0, B0, "buf0");
    chk(cmd_a_q.size() == LINES, "R3", "exactly LINES commands", cmd_a_q.size(), LINES);
    chk(drop_cnt == 0, "R10", "no drop on clean frame", drop_cnt, 0);
  endtask

  task automatic t_idle();
    repeat (30) @(negedge clk);
    chk(cmd_a_q.size() == LINES, "R9", "no command after last line", cmd_a_q.size(), LINES);
  endtask

  task automatic t_buf1_gaps();
    clear_logs();
    stall_mode = 1; gap_mode = 1;
    pulse_done(1'b1);
    wait_px(FPIX);
    repeat (4) @(negedge clk);
    check_frame(0, 0, B1, "buf1 gaps");
    chk(stall_cnt == 0, "R6", "ready held during gapped bursts", stall_cnt, 0);
    stall_mode = 0; gap_mode = 0;
  endtask

  task automatic t_afull();
    int t;
    clear_logs();
    @(negedge clk); ds_afull_i = 1'b1;
    pulse_done(1'b0);
    repeat (20) @(negedge clk);
    chk(cmd_a_q.size() == 0, "R5", "no command while almost full", cmd_a_q.size(), 0);
    ds_afull_i = 1'b0;
    t = 0;
    while (cmd_a_q.size() < 1 && t < 100) begin @(negedge clk); t++; end
    ds_afull_i = 1'b1;
    repeat (12) @(negedge clk);
    chk(px_d_q.size() == LINE_PIX, "R6", "burst completes under almost full",
        px_d_q.size(), LINE_PIX);
    chk(cmd_a_q.size() == 1, "R5", "next line held by almost full", cmd_a_q.size(), 1);
    ds_afull_i = 1'b0;
    wait_px(FPIX);
    repeat (4) @(negedge clk);
    check_frame(0, 0, B0, "afull");
    chk(stall_cnt == 0, "R6", "no beat refused", stall_cnt, 0);
  endtask

  task automatic t_drop();
    int t;
    clear_logs();
    pulse_done(1'b0);
    t = 0;
    while (cmd_a_q.size() < 1 && t < 100) begin @(negedge clk); t++; end
    pulse_done(1'b1);
    wait_px(2 * FPIX);
    repeat (20) @(negedge clk);
    chk(drop_cnt == 1, "R10", "single drop pulse", drop_cnt, 1);
    check_frame(0, 0, B0, "drop current");
    check_frame(LINES, FPIX, B1, "drop newest");
    chk(cmd_a_q.size() == 2 * LINES, "R9", "idle after newest frame", cmd_a_q.size(), 2 * LINES);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_idle();
    t_buf1_gaps();
    t_afull();
    t_drop();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule